// File: doc/BRIEF.md
# Four-Plane Pixel Write/Read Datapath

This block moves pixel bytes between a host byte bus and display memory. The memory is organised as four 8-bit planes that share one offset, so every location holds a 32-bit word. A host write goes through one of four write modes. Each mode builds one byte per plane from some mix of these sources: the host byte rotated right, bits expanded from a per-plane set/reset value, a logic operation against a 32-bit latch, and a per-bit mask that keeps latch bits. Only the planes enabled in the plane write mask are then stored. A host read loads the whole 32-bit word at the offset into the latch. It returns either one chosen plane's byte or a colour-compare byte in which every bit marks a pixel that matches a reference colour.

Host accesses use a valid/ready request channel, and read results come back on a valid/ready response channel. The block accepts a request on a cycle where `host_valid` and `host_ready` are both high. While a read response is waiting, `host_ready` is low, so back-pressure on the response channel stalls new requests. A response that is not consumed keeps its data unchanged. The control registers are loaded through a plain index/data write port. The planes live inside the block, and `OFF_W` sets the number of offsets.

Top module: `planar_pixel_path`

## Requirements
- R1: After reset the planes and the latch are zero, `rsp_valid` is 0 and `host_ready` is 1. The registers reset to: bit mask 0xFF, plane write mask 0xF, all others 0.
- R2: A read accepted at a clock edge raises `rsp_valid` after that edge. `rsp_valid` and `rsp_data` hold until a cycle with `rsp_ready` high. `host_ready` is low whenever `rsp_valid` is high.
- R3: Write mode 0: the host byte is rotated right by the rotate count. For each plane p whose enable-set/reset bit is 1, the data becomes set/reset bit p repeated over 8 bits.
- R4: In write modes 0, 2 and 3 a logic operation combines the data with the latch byte of the same plane. The encodings are 0 = pass data, 1 = AND, 2 = OR, 3 = XOR.
- R5: The bit mask picks each result bit: the operation result where the mask bit is 1, and the latch bit where it is 0.
- R6: A write changes only the planes whose bit in the plane write mask is 1. The other planes keep their content.
- R7: Write mode 1 stores the latch byte of each enabled plane and ignores the host byte.
- R8: Write mode 2: for plane p, host bit p is repeated over all 8 bits before the logic operation and the bit mask.
- R9: Write mode 3: the data of every plane is set/reset bit p repeated. The effective bit mask is the rotated host byte AND the bit mask.
- R10: Read mode 0 returns the byte of the plane given by the read plane select.
- R11: Read mode 1 sets bit j when, for every plane p with care bit p = 1, memory bit j of plane p equals compare bit p. Planes with care bit 0 are left out.
- R12: Each read loads all four plane bytes at its offset into the latch. Writes leave the latch unchanged.
- R13: Register index map, written with `cfg_wr`:
  - 0: set/reset [3:0]
  - 1: enable set/reset [3:0]
  - 2: compare colour [3:0]
  - 3: rotate count [2:0] and logic operation [4:3]
  - 4: read plane select [1:0]
  - 5: write mode [1:0] and read mode [3]
  - 6: care mask [3:0]
  - 7: bit mask [7:0]
  - 8: plane write mask [3:0]

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 8 | Register write data |
| host_valid | input | 1 | Request valid |
| host_ready | output | 1 | Request can be accepted |
| host_write | input | 1 | 1 = write request, 0 = read request |
| host_off | input | OFF_W | Plane offset |
| host_wdata | input | 8 | Host write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 8 | Read response byte |

## Verification
The assertions check the response handshake on every cycle. They cover three things: a response appears after each accepted read, it stays stable while stalled, and requests are blocked while it waits. They also check that a write never disturbs the latch, and that a mode 0 read returns exactly the selected latch byte.

The arithmetic of the write modes cannot be seen at any single cycle. This covers rotation, set/reset substitution, the logic operations, mask merging, plane enables and the colour compare. Only the bench's scenarios can show it: they write through a mode and then read every plane back against a model.

// File: rtl/ppp_pkg.sv
package ppp_pkg;
  localparam int NPL  = 4;
  localparam int BW   = 8;
  localparam int WW   = NPL * BW;
  localparam int RC_W = 3;

  typedef enum logic [1:0] {
    LOP_PASS = 2'd0,
    LOP_AND  = 2'd1,
    LOP_OR   = 2'd2,
    LOP_XOR  = 2'd3
  } lop_e;

  typedef enum logic [1:0] {
    WM_ALU   = 2'd0,
    WM_LATCH = 2'd1,
    WM_SPLAT = 2'd2,
    WM_MASKD = 2'd3
  } wmode_e;

  typedef struct packed {
    logic [NPL-1:0]  sr;
    logic [NPL-1:0]  esr;
    logic [NPL-1:0]  cmp;
    logic [RC_W-1:0] rot;
    lop_e            lop;
    logic [1:0]      rsel;
    wmode_e          wmode;
    logic            rmode;
    logic [NPL-1:0]  care;
    logic [BW-1:0]   bmask;
    logic [NPL-1:0]  pmask;
  } cfg_t;
endpackage

// File: rtl/ppp_cfg_regs.sv
module ppp_cfg_regs
  import ppp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_idx,
  input  logic [7:0] cfg_wdata,
  output cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      cfg.bmask <= '1;
      cfg.pmask <= '1;
    end else if (cfg_wr) begin
      case (cfg_idx)
        4'd0: cfg.sr    <= cfg_wdata[NPL-1:0];
        4'd1: cfg.esr   <= cfg_wdata[NPL-1:0];
        4'd2: cfg.cmp   <= cfg_wdata[NPL-1:0];
        4'd3: begin
          cfg.rot <= cfg_wdata[RC_W-1:0];
          cfg.lop <= lop_e'(cfg_wdata[4:3]);
        end
        4'd4: cfg.rsel  <= cfg_wdata[1:0];
        4'd5: begin
          cfg.wmode <= wmode_e'(cfg_wdata[1:0]);
          cfg.rmode <= cfg_wdata[3];
        end
        4'd6: cfg.care  <= cfg_wdata[NPL-1:0];
        4'd7: cfg.bmask <= cfg_wdata;
        4'd8: cfg.pmask <= cfg_wdata[NPL-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ppp_write_lane.sv
module ppp_write_lane
  import ppp_pkg::*;
#(
  parameter int LANE = 0
) (
  input  cfg_t          cfg,
  input  logic [BW-1:0] host_byte,
  input  logic [BW-1:0] latch_byte,
  output logic [BW-1:0] out_byte
);
  logic [2*BW-1:0] dbl;
  logic [BW-1:0]   rot8, src, eff, alu;

  assign dbl  = {host_byte, host_byte} >> cfg.rot;
  assign rot8 = dbl[BW-1:0];

  always_comb begin
    src = rot8;
    eff = cfg.bmask;
    unique case (cfg.wmode)
      WM_ALU:   src = cfg.esr[LANE] ? {BW{cfg.sr[LANE]}} : rot8;
      WM_LATCH: src = latch_byte;
      WM_SPLAT: src = {BW{host_byte[LANE]}};
      WM_MASKD: begin
        src = {BW{cfg.sr[LANE]}};
        eff = rot8 & cfg.bmask;
      end
    endcase
  end

  always_comb begin
    unique case (cfg.lop)
      LOP_PASS: alu = src;
      LOP_AND:  alu = src & latch_byte;
      LOP_OR:   alu = src | latch_byte;
      LOP_XOR:  alu = src ^ latch_byte;
    endcase
  end

  assign out_byte = (cfg.wmode == WM_LATCH) ? latch_byte
                                            : ((alu & eff) | (latch_byte & ~eff));
endmodule

// File: rtl/ppp_read_unit.sv
module ppp_read_unit
  import ppp_pkg::*;
(
  input  cfg_t          cfg,
  input  logic [WW-1:0] word,
  output logic [BW-1:0] rd_byte
);
  logic [BW-1:0] match;

  always_comb begin
    for (int j = 0; j < BW; j++) begin
      match[j] = 1'b1;
      for (int p = 0; p < NPL; p++) begin
        if (cfg.care[p] && (word[p*BW+j] != cfg.cmp[p])) match[j] = 1'b0;
      end
    end
  end

  assign rd_byte = cfg.rmode ? match : word[cfg.rsel*BW +: BW];
endmodule

// File: rtl/ppp_plane_store.sv
module ppp_plane_store
  import ppp_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPL-1:0]   we,
  input  logic [OFF_W-1:0] off,
  input  logic [WW-1:0]    wdata,
  output logic [WW-1:0]    rdata
);
  localparam int DEPTH = 1 << OFF_W;

  for (genvar p = 0; p < NPL; p++) begin : g_plane
    logic [BW-1:0] arr [DEPTH];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
      end else if (we[p]) begin
        arr[off] <= wdata[p*BW +: BW];
      end
    end
    assign rdata[p*BW +: BW] = arr[off];
  end
endmodule

// File: rtl/planar_pixel_path.sv
module planar_pixel_path
  import ppp_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [3:0]       cfg_idx,
  input  logic [7:0]       cfg_wdata,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_write,
  input  logic [OFF_W-1:0] host_off,
  input  logic [7:0]       host_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data
);
  cfg_t          cfg_q;
  logic [WW-1:0] latch_q, word, wr_word;
  logic [BW-1:0] rd_byte;
  logic          acc, wr_acc, rd_acc;
  logic [NPL-1:0] we;

  assign host_ready = ~rsp_valid;
  assign acc        = host_valid & host_ready;
  assign wr_acc     = acc & host_write;
  assign rd_acc     = acc & ~host_write;
  assign we         = {NPL{wr_acc}} & cfg_q.pmask;

  ppp_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg(cfg_q)
  );

  for (genvar p = 0; p < NPL; p++) begin : g_lane
    ppp_write_lane #(.LANE(p)) u_lane (
      .cfg(cfg_q), .host_byte(host_wdata),
      .latch_byte(latch_q[p*BW +: BW]), .out_byte(wr_word[p*BW +: BW])
    );
  end

  ppp_plane_store #(.OFF_W(OFF_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .off(host_off),
    .wdata(wr_word), .rdata(word)
  );

  ppp_read_unit u_rd (.cfg(cfg_q), .word(word), .rd_byte(rd_byte));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rd_acc) begin
        latch_q   <= word;
        rsp_valid <= 1'b1;
        rsp_data  <= rd_byte;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/planar_pixel_path_chk.sv
module planar_pixel_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_valid,
  input logic        host_ready,
  input logic        host_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic [31:0] latch,
  input logic        rmode,
  input logic [1:0]  rsel
);
  logic       rd_acc, wr_acc, r0_pend;
  logic [1:0] sel_d;

  assign rd_acc = host_valid && host_ready && !host_write;
  assign wr_acc = host_valid && host_ready && host_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r0_pend <= 1'b0;
      sel_d   <= '0;
    end else begin
      r0_pend <= rd_acc && !rmode;
      sel_d   <= rsel;
    end
  end

  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R2
  stall_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !host_ready);

  // R12
  latch_kept_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> $stable(latch));

  // R10
  plane_read_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r0_pend |-> (rsp_data == latch[sel_d*8 +: 8]));
endmodule

bind planar_pixel_path planar_pixel_path_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
  .host_write(host_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .latch(latch_q), .rmode(cfg_q.rmode), .rsel(cfg_q.rsel)
);

// File: tb/planar_pixel_path_bench.sv
module planar_pixel_path_bench;
  localparam int OFF_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0; logic [3:0] cfg_idx = 0; logic [7:0] cfg_wdata = 0;
  logic host_valid = 0, host_write = 0, rsp_ready = 0;
  logic [OFF_W-1:0] host_off = 0; logic [7:0] host_wdata = 0;
  logic host_ready, rsp_valid; logic [7:0] rsp_data;

  always #4 clk = ~clk;

  planar_pixel_path #(.OFF_W(OFF_W)) u_planar_pixel_path (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_off(host_off), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] mem_m [4][256];
  logic [31:0] latch_m;
  logic [3:0] m_sr, m_esr, m_cmp, m_care, m_pm;
  logic [2:0] m_rot; logic [1:0] m_lop, m_rsel, m_wm; logic m_rm;
  logic [7:0] m_bm;

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [7:0] v);
    @(negedge clk); cfg_wr = 1; cfg_idx = idx; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
    case (idx)
      0: m_sr = v[3:0];  1: m_esr = v[3:0]; 2: m_cmp = v[3:0];
      3: begin m_rot = v[2:0]; m_lop = v[4:3]; end
      4: m_rsel = v[1:0];
      5: begin m_wm = v[1:0]; m_rm = v[3]; end
      6: m_care = v[3:0]; 7: m_bm = v; 8: m_pm = v[3:0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] lane(int p, logic [7:0] d);
    logic [15:0] dd; logic [7:0] r, s, e, a, l;
    dd = {d, d} >> m_rot; r = dd[7:0]; l = latch_m[p*8 +: 8];
    e = m_bm;
    case (m_wm)
      2'd0: s = m_esr[p] ? {8{m_sr[p]}} : r;
      2'd1: return l;
      2'd2: s = {8{d[p]}};
      default: begin s = {8{m_sr[p]}}; e = r & m_bm; end
    endcase
    case (m_lop)
      2'd0: a = s; 2'd1: a = s & l; 2'd2: a = s | l; default: a = s ^ l;
    endcase
    return (a & e) | (l & ~e);
  endfunction

  function automatic logic [7:0] rd_exp(int off);
    logic [7:0] m;
    if (!m_rm) return mem_m[m_rsel][off];
    for (int j = 0; j < 8; j++) begin
      m[j] = 1'b1;
      for (int p = 0; p < 4; p++)
        if (m_care[p] && mem_m[p][off][j] != m_cmp[p]) m[j] = 1'b0;
    end
    return m;
  endfunction

  task automatic wr(input int off, input logic [7:0] d);
    for (int p = 0; p < 4; p++)
      if (m_pm[p]) mem_m[p][off] = lane(p, d);
    @(negedge clk); host_valid = 1; host_write = 1; host_off = off[7:0]; host_wdata = d;
    @(negedge clk); host_valid = 0;
  endtask

  task automatic rd(input int off, input string tag);
    logic [7:0] e;
    e = rd_exp(off);
    @(negedge clk); host_valid = 1; host_write = 0; host_off = off[7:0];
    @(negedge clk); host_valid = 0;
    check({tag, " rsp_valid"}, {7'd0, rsp_valid}, 8'd1);
    check(tag, rsp_data, e);
    for (int p = 0; p < 4; p++) latch_m[p*8 +: 8] = mem_m[p][off];
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
  endtask

  task automatic rd_planes(input int off, input string tag);
    cfg(5, {4'd0, 2'b00, m_wm});
    for (int p = 0; p < 4; p++) begin cfg(4, 8'(p)); rd(off, tag); end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int seed;
    string tg;
    seed = $urandom(32'd20240611);
    for (int p = 0; p < 4; p++) for (int i = 0; i < 256; i++) mem_m[p][i] = 0;
    latch_m = 0; m_sr = 0; m_esr = 0; m_cmp = 0; m_care = 0; m_pm = 4'hF;
    m_rot = 0; m_lop = 0; m_rsel = 0; m_wm = 0; m_rm = 0; m_bm = 8'hFF;
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);

    // R1 reset state
    check("R1 host_ready", {7'd0, host_ready}, 8'd1);
    check("R1 rsp_valid", {7'd0, rsp_valid}, 8'd0);
    rd(5, "R1 reset read");
    wr(6, 8'hA5); rd_planes(6, "R1 default masks");

    // R3 rotate + set/reset substitution, R13 index map
    cfg(3, 8'h03); cfg(1, 8'h05); cfg(0, 8'h04);
    wr(10, 8'h81); rd_planes(10, "R3 rot sr");
    cfg(3, 8'h07); cfg(1, 8'h00); wr(11, 8'h01); rd_planes(11, "R3 rot7");

    // R4 logic operations against latch
    for (int op = 0; op < 4; op++) begin
      cfg(1, 0); cfg(3, 8'(op << 3));
      wr(20 + op, 8'h3C); rd(20 + op, "R4 seed");
      wr(20 + op, 8'h5A); rd_planes(20 + op, "R4 lop");
    end
    cfg(3, 0);

    // R5 bit mask
    wr(30, 8'hF0); rd(30, "R5 seed"); cfg(7, 8'h0F);
    wr(30, 8'h3C); rd_planes(30, "R5 bitmask"); cfg(7, 8'hFF);

    // R6 plane write mask
    wr(31, 8'h11); cfg(8, 8'h06); wr(31, 8'hEE); rd_planes(31, "R6 pmask"); cfg(8, 8'h0F);

    // R7 / R12 latch copy, writes keep latch
    wr(40, 8'h12); cfg(0, 8'h0A); cfg(1, 8'h0A); wr(40, 8'h34);
    rd(40, "R12 load");
    cfg(5, 8'h01); wr(41, 8'hFF); wr(42, 8'h00);
    rd_planes(41, "R7 latch copy"); cfg(5, 8'h01);
    rd(0, "R12 reload"); cfg(5, 8'h01); wr(43, 8'h77); rd_planes(43, "R12 latch kept");

    // R8 host bit splat
    cfg(5, 8'h02); cfg(7, 8'hC3); wr(50, 8'h09); rd_planes(50, "R8 splat"); cfg(7, 8'hFF);

    // R9 masked set/reset
    cfg(5, 8'h03); cfg(0, 8'h09); cfg(3, 8'h02); cfg(7, 8'h7E);
    rd(50, "R9 seed"); cfg(5, 8'h03); wr(51, 8'hB4); rd_planes(51, "R9 masked");

    // R11 colour compare
    cfg(2, 8'h05); cfg(6, 8'h0F); cfg(5, 8'h08); rd(51, "R11 cmp all");
    cfg(6, 8'h00); rd(51, "R11 none care"); cfg(6, 8'h0A); rd(50, "R11 partial");

    // R2 back-pressure
    cfg(5, 8'h00); cfg(4, 8'h01);
    @(negedge clk); host_valid = 1; host_write = 0; host_off = 8'd50;
    @(negedge clk); host_valid = 1; host_write = 1; host_wdata = 8'hFF;
    check("R2 stall", {7'd0, host_ready}, 8'd0);
    @(negedge clk); host_valid = 0;
    check("R2 hold", rsp_data, mem_m[1][50]);
    check("R2 valid hold", {7'd0, rsp_valid}, 8'd1);
    for (int p = 0; p < 4; p++) latch_m[p*8 +: 8] = mem_m[p][50];
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    check("R2 release", {7'd0, rsp_valid}, 8'd0);
    rd(50, "R2 no stray write");

    // constrained random
    for (int it = 0; it < 250; it++) begin
      int off;
      off = $urandom_range(63, 0);
      cfg(0, 8'($urandom)); cfg(1, 8'($urandom)); cfg(3, 8'($urandom));
      cfg(7, 8'($urandom)); cfg(8, 8'($urandom_range(15, 1)));
      cfg(5, 8'($urandom_range(3, 0)));
      if ($urandom_range(1, 0) == 1) rd($urandom_range(63, 0), "R12 rnd load");
      case (m_wm) 2'd0: tg = "R3 rnd"; 2'd1: tg = "R7 rnd"; 2'd2: tg = "R8 rnd"; default: tg = "R9 rnd"; endcase
      wr(off, 8'($urandom));
      rd_planes(off, tg);
      cfg(2, 8'($urandom)); cfg(6, 8'($urandom)); cfg(5, 8'h08);
      rd(off, "R11 rnd");
    end
    summary();
  end
endmodule